// File: doc/BRIEF.md
# Packed Four-Lane Saturating Add/Subtract Unit

This unit takes two 64-bit words, each holding four independent 16-bit integers, and adds or subtracts them lane by lane in a single pass. Carries and borrows stop at every 16-bit boundary, so each lane behaves as its own 16-bit adder. A two-bit control code chooses how a lane result that leaves its range is handled: it can wrap around, clamp to the signed 16-bit limits, or clamp to the unsigned 16-bit limits.

The operands, the direction select and the control code are accepted on any clock edge where the input strobe is high. The lane results come out of a register on the next edge, together with an output strobe. A new operation may be issued on every cycle. When the input strobe is low, the result register keeps its value.

Top module: `simd_sat_addsub`

## Requirements
- R1: Each 16-bit lane i (bits 16i+15..16i, i = 0..3) is computed only from the same lane of both operands; a carry or borrow out of one lane never reaches the next lane.
- R2: With `sub_i`=0 a lane computes a+b, and with `sub_i`=1 it computes a-b.
- R3: With mode code 2'b00 or 2'b11, each lane result is the low 16 bits of the exact result (wraparound modulo 65536).
- R4: With mode code 2'b01, lanes are read as two's-complement numbers. A result above 32767 gives 0x7FFF, a result below -32768 gives 0x8000, and any other result is exact.
- R5: With mode code 2'b10, lanes are read as unsigned numbers. An add result above 65535 gives 0xFFFF, a subtract result below 0 gives 0x0000, and any other result is exact.
- R6: `res_o` and `vld_o` show the result of an operation on the clock edge after the one on which `vld_i` was high, so one operation can be accepted every cycle.
- R7: `vld_o` equals `vld_i` delayed by one cycle. While `vld_i` is low, `res_o` keeps its previous value.
- R8: Synchronous active-high `rst_i` clears `res_o` to 0 and `vld_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| vld_i | input | 1 | Operation strobe |
| sub_i | input | 1 | 0 = add, 1 = subtract |
| mode_i | input | 2 | 00/11 wrap, 01 signed clamp, 10 unsigned clamp |
| a_i | input | 64 | First operand, four 16-bit lanes |
| b_i | input | 64 | Second operand, four 16-bit lanes |
| res_o | output | 64 | Registered lane results |
| vld_o | output | 1 | Result strobe |

## Verification
The assertions assume that the control inputs are never X and that the operand and control inputs are only meaningful on cycles where `vld_i` is high. The bench follows this. It drives known values on every cycle, including idle ones, and changes operands while the strobe is low only to show that the held result does not move. The stimulus covers directed lane values at each clamp edge and in every mode, then a long run of random operands with the strobe toggling at random.

// File: rtl/simd_sat_addsub.sv
module simd_sat_addsub #(
  parameter int LANE_W = 16,
  parameter int LANES  = 4,
  localparam int DW    = LANE_W * LANES
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          vld_i,
  input  logic          sub_i,
  input  logic [1:0]    mode_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] res_o,
  output logic          vld_o
);

  localparam logic [LANE_W-1:0] SMAX = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] SMIN = {1'b1, {(LANE_W-1){1'b0}}};

  logic [DW-1:0] lane_res;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] a, b, bx;
    logic [LANE_W:0]   sum;
    logic              s_ovf, u_ovf;
    assign a   = a_i[g*LANE_W +: LANE_W];
    assign b   = b_i[g*LANE_W +: LANE_W];
    assign bx  = sub_i ? ~b : b;
    assign sum = {1'b0, a} + {1'b0, bx} + {{LANE_W{1'b0}}, sub_i};
    assign s_ovf = (a[LANE_W-1] == bx[LANE_W-1]) && (sum[LANE_W-1] != a[LANE_W-1]);
    assign u_ovf = sum[LANE_W] ^ sub_i;

    always_comb begin
      lane_res[g*LANE_W +: LANE_W] = sum[LANE_W-1:0];
      if (mode_i == 2'b01 && s_ovf)
        lane_res[g*LANE_W +: LANE_W] = a[LANE_W-1] ? SMIN : SMAX;
      else if (mode_i == 2'b10 && u_ovf)
        lane_res[g*LANE_W +: LANE_W] = sub_i ? '0 : '1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      res_o <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) res_o <= lane_res;
    end
  end

endmodule

module simd_sat_addsub_chk #(
  parameter int LANE_W = 16,
  parameter int LANES  = 4,
  localparam int DW    = LANE_W * LANES
) (
  input logic          clk_i,
  input logic          rst_i,
  input logic          vld_i,
  input logic          sub_i,
  input logic [1:0]    mode_i,
  input logic [DW-1:0] a_i,
  input logic [DW-1:0] b_i,
  input logic [DW-1:0] res_o,
  input logic          vld_o
);
  logic past_ok;
  always_ff @(posedge clk_i) past_ok <= !rst_i;

  AST_VLD_DELAY: assert property (@(posedge clk_i) disable iff (rst_i)
    past_ok |-> vld_o == $past(vld_i)); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
    past_ok && !$past(vld_i) |-> $stable(res_o)); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    $past(rst_i) |-> res_o == '0 && !vld_o); // R8
  AST_USAT_ADD_FLOOR: assert property (@(posedge clk_i) disable iff (rst_i)
    past_ok && $past(vld_i) && $past(mode_i) == 2'b10 && !$past(sub_i)
      |-> res_o[LANE_W-1:0] >= $past(a_i[LANE_W-1:0])); // R5
  AST_USAT_SUB_CEIL: assert property (@(posedge clk_i) disable iff (rst_i)
    past_ok && $past(vld_i) && $past(mode_i) == 2'b10 && $past(sub_i)
      |-> res_o[LANE_W-1:0] <= $past(a_i[LANE_W-1:0])); // R5
  AST_WRAP_ADD: assert property (@(posedge clk_i) disable iff (rst_i)
    past_ok && $past(vld_i) && $past(mode_i) == 2'b00 && !$past(sub_i)
      |-> res_o[LANE_W-1:0] == LANE_W'($past(a_i[LANE_W-1:0]) + $past(b_i[LANE_W-1:0]))); // R3
endmodule

bind simd_sat_addsub simd_sat_addsub_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (.*);

// File: tb/simd_sat_addsub_tb.sv
module simd_sat_addsub_tb;
  logic clk = 0, rst = 1, vld = 0, sub = 0;
  logic [1:0] mode = 0;
  logic [63:0] a = 0, b = 0;
  logic [63:0] res;
  logic vo;
  int checks = 0, errors = 0;
  logic [63:0] exp_res = 0;
  logic exp_vld = 0;

  always #10 clk = ~clk;

  simd_sat_addsub u_dut (.clk_i(clk), .rst_i(rst), .vld_i(vld), .sub_i(sub),
    .mode_i(mode), .a_i(a), .b_i(b), .res_o(res), .vld_o(vo));

  function automatic logic [15:0] lane_ref(input logic [15:0] x, input logic [15:0] y,
                                          input logic s, input logic [1:0] m);
    int sv, uv;
    sv = s ? ($signed(x) - $signed(y)) : ($signed(x) + $signed(y));
    uv = s ? (int'(x) - int'(y)) : (int'(x) + int'(y));
    if (m == 2'b01) begin
      if (sv > 32767) return 16'h7FFF;
      if (sv < -32768) return 16'h8000;
      return sv[15:0];
    end
    if (m == 2'b10) begin
      if (uv > 65535) return 16'hFFFF;
      if (uv < 0) return 16'h0000;
      return uv[15:0];
    end
    return uv[15:0];
  endfunction

  always @(posedge clk) begin
    if (rst) begin exp_res <= 0; exp_vld <= 0; end
    else begin
      exp_vld <= vld;
      if (vld)
        for (int i = 0; i < 4; i++)
          exp_res[i*16 +: 16] <= lane_ref(a[i*16 +: 16], b[i*16 +: 16], sub, mode);
    end
  end

  // Compare on every falling edge (R1-related lane independence covered by lane_ref per lane)
  always @(negedge clk) begin
    checks++;
    if (res !== exp_res || vo !== exp_vld) begin
      errors++;
      $display("FAIL R1 R2 R3 R4 R5 R6 R7 R8: res=%h vld=%b expected res=%h vld=%b (mode=%0d sub=%b)",
               res, vo, exp_res, exp_vld, mode, sub);
    end
  end

  task automatic op(input logic [63:0] x, input logic [63:0] y, input logic s,
                    input logic [1:0] m, input logic v);
    @(posedge clk); #1;
    a = x; b = y; sub = s; mode = m; vld = v;
  endtask

  initial begin
    fork
      begin #4000000; errors++; $display("FAIL watchdog: expected completion"); end
    join_none
    repeat (3) @(posedge clk);
    #1;
    // R8 reset state
    checks++;
    if (res !== 0 || vo !== 0) begin errors++; $display("FAIL R8: res=%h vld=%b expected 0 0", res, vo); end
    rst = 0;
    // R1: lane carry does not cross boundary
    op(64'h0001_FFFF_0001_FFFF, 64'h0000_0001_0000_0001, 0, 2'b00, 1);
    // R2 subtract with borrow isolation
    op(64'h0000_0000_0005_0000, 64'h0000_0001_0003_0001, 1, 2'b00, 1);
    // R4 signed clamps
    op(64'h7FFF_8000_7000_0005, 64'h0001_0001_0FFF_0003, 0, 2'b01, 1);
    op(64'h8000_7FFF_8001_0000, 64'h0001_FFFF_0001_8000, 1, 2'b01, 1);
    // R5 unsigned clamps
    op(64'hFFFF_FFF0_0001_1234, 64'h0001_000F_FFFF_0000, 0, 2'b10, 1);
    op(64'h0000_0010_0001_1234, 64'h0001_0010_0002_1234, 1, 2'b10, 1);
    // R3 mode 11 wraps
    op(64'h7FFF_FFFF_0000_8000, 64'h0001_0001_0001_8000, 0, 2'b11, 1);
    // R7 hold with changing inputs
    op(64'hDEAD_BEEF_0123_4567, 64'hFFFF_FFFF_FFFF_FFFF, 0, 2'b10, 0);
    op(64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 1, 2'b01, 0);
    // R6 back to back random
    for (int k = 0; k < 3000; k++)
      op({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), 2'($urandom), ($urandom % 4) != 0);
    // R8 mid-run reset
    @(posedge clk); #1; rst = 1; vld = 1;
    @(posedge clk); #1; rst = 0; vld = 0;
    @(posedge clk); #1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule